// File: doc/BRIEF.md
# Two-Deep Queued Transfer Sequencer

This block is the control core of a memory-to-peripheral DMA channel. It has room for one running transfer and one queued transfer. Software uses a small register port with word-wide access. Through it, software loads a start address and a length in 32-bit words, then issues start, cancel and halt commands. The core passes the address and length of the running transfer to a separate transfer engine with a one-cycle launch pulse. The engine reports back with a one-cycle completion pulse.

If a transfer is queued when the running one completes, the queued values are launched on the very next cycle, so there is no idle gap between the two. Commands that arrive in a state where they make no sense are either ignored or flagged in a sticky error bit. A halt command aborts the engine and clears every register.

The core has three states. IDLE (status code 00) means nothing is running. RUN (01) means one transfer is in flight. RUN_QUEUED (10) means one transfer is in flight and the next one is waiting. The transitions are:
- start: IDLE to RUN, which launches a transfer.
- queue: RUN to RUN_QUEUED, caused by a start command.
- chain: RUN_QUEUED to RUN, when a completion launches the queued transfer.
- finish: RUN to IDLE, on completion.
- cancel: RUN_QUEUED to RUN.
- halt: any state to IDLE.

Top module: `dmaq_seq`

## Requirements
- R1: Register index 1 reads the status in bits 1:0: 00 means IDLE, 01 RUN, 10 RUN_QUEUED. The other bits read 0. After reset the status is 00 and every register reads 0.
- R2: Bit 0 of a command write (register index 0) is the start command. Issued in IDLE with a non-zero queued length, it copies the queued address (index 3) and length (index 4) into the active address (index 5) and active length (index 6). It also drives those values on eng_addr and eng_words and pulses eng_start for one cycle, in the cycle after the write. The status becomes RUN.
- R3: A start command in RUN moves the core to RUN_QUEUED without a launch. A start command in RUN_QUEUED is discarded and sets bit 0 of the error register (index 2). That bit stays set until software writes 1 to bit 0 of index 2. Writing 0 leaves it unchanged.
- R4: A completion pulse in RUN_QUEUED (with a non-zero queued length) copies the queued values into the active registers and pulses eng_start in the next cycle, leaving the status RUN. A completion in RUN returns the core to IDLE. A completion in IDLE is ignored.
- R5: Bit 1 of a command write is the cancel command. In RUN_QUEUED it drops the queued transfer and returns the core to RUN without a launch. In IDLE or RUN it has no effect.
- R6: Bit 2 of a command write is the halt command. It returns the core to IDLE and sets every register, the engine outputs included, to 0. In the next cycle it pulses eng_abort once, but only if a transfer was running.
- R7: A start command with a queued length of 0 has no effect in any state: it causes no launch, no status change and no error. A completion in RUN_QUEUED whose queued length is 0 returns the core to IDLE without a launch.
- R8: The queued address keeps bits 31:2 of the written word. Bits 1:0 of the queued address and of the active address always read 0. The length registers keep 16 bits.
- R9: Register index 7 is a 32-bit scratch register that software can read and write. It has no effect on the sequencer.
- R10: A write is accepted only when all four byte enables are set. Any other write changes nothing. Writes to the read-only indices 1, 5 and 6 are ignored. The command register reads 0.
- R11: Within one command write, halt takes precedence over cancel, and cancel takes precedence over start. When a completion pulse and a command arrive in the same cycle, the completion is applied first and the command is judged against the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register index for reads and writes |
| reg_be | input | 4 | Byte enables; only 4'hF writes take effect |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_sel (combinational) |
| eng_start | output | 1 | One-cycle launch pulse to the transfer engine |
| eng_abort | output | 1 | One-cycle abort pulse after a halt of a running transfer |
| eng_addr | output | ADDR_W | Active start address |
| eng_words | output | LEN_W | Active length in words |
| eng_done | input | 1 | One-cycle completion pulse from the engine |

## Verification
Several properties are checked on every cycle: the status never takes the unused code 11, a launch never carries a zero length, addresses stay word aligned, and a halt clears the state and registers on the next edge. The same per-cycle checks cover the error set on a start in RUN_QUEUED, the chained launch on completion, and cancel returning the core to RUN. Other behaviour can only be shown by the bench's scenarios against its reference model. That covers sticky clearing of the error bit, the scratch register having no effect, partial and read-only writes being ignored, the precedence of a completion arriving together with a command, and long random mixes of commands, completions and register updates.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'b00,
        ST_RUN        = 2'b01,
        ST_RUN_QUEUED = 2'b10
    } seq_state_t;

    localparam int unsigned SEL_W = 3;

    localparam logic [SEL_W-1:0] IX_CMD     = 3'd0;
    localparam logic [SEL_W-1:0] IX_STAT    = 3'd1;
    localparam logic [SEL_W-1:0] IX_ERR     = 3'd2;
    localparam logic [SEL_W-1:0] IX_QADDR   = 3'd3;
    localparam logic [SEL_W-1:0] IX_QLEN    = 3'd4;
    localparam logic [SEL_W-1:0] IX_AADDR   = 3'd5;
    localparam logic [SEL_W-1:0] IX_ALEN    = 3'd6;
    localparam logic [SEL_W-1:0] IX_SCRATCH = 3'd7;

    localparam int unsigned CMD_GO_BIT   = 0;
    localparam int unsigned CMD_DROP_BIT = 1;
    localparam int unsigned CMD_HALT_BIT = 2;

endpackage

// File: rtl/dmaq_cfg.sv
module dmaq_cfg
    import dmaq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_ok,
    input  logic [SEL_W-1:0]  sel,
    input  logic [31:0]       wdata,
    input  logic              err_set,
    output logic [ADDR_W-1:0] q_addr,
    output logic [LEN_W-1:0]  q_len,
    output logic [31:0]       scratch,
    output logic              op_err
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q_addr  <= '0;
            q_len   <= '0;
            scratch <= '0;
            op_err  <= 1'b0;
        end else begin
            if (wr_ok && sel == IX_QADDR)   q_addr  <= {wdata[ADDR_W-1:2], 2'b00};
            if (wr_ok && sel == IX_QLEN)    q_len   <= wdata[LEN_W-1:0];
            if (wr_ok && sel == IX_SCRATCH) scratch <= wdata;
            if (err_set)
                op_err <= 1'b1;
            else if (wr_ok && sel == IX_ERR && wdata[0])
                op_err <= 1'b0;
        end
    end

endmodule

// File: rtl/dmaq_ctl.sv
module dmaq_ctl
    import dmaq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              drop,
    input  logic              halt,
    input  logic              done,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [LEN_W-1:0]  q_len,
    output seq_state_t        st,
    output logic [ADDR_W-1:0] a_addr,
    output logic [LEN_W-1:0]  a_len,
    output logic              launch,
    output logic              abort,
    output logic              err_set
);

    seq_state_t mid_st, nxt_st;
    logic       mid_launch, nxt_launch;
    logic       q_nonzero;

    assign q_nonzero = (q_len != '0);

    always_comb begin
        mid_st     = st;
        mid_launch = 1'b0;
        unique case (st)
            ST_IDLE: mid_st = ST_IDLE;
            ST_RUN: begin
                if (done) mid_st = ST_IDLE;
            end
            ST_RUN_QUEUED: begin
                if (done) begin
                    if (q_nonzero) begin
                        mid_st     = ST_RUN;
                        mid_launch = 1'b1;
                    end else begin
                        mid_st = ST_IDLE;
                    end
                end
            end
            default: mid_st = ST_IDLE;
        endcase

        nxt_st     = mid_st;
        nxt_launch = mid_launch;
        err_set    = 1'b0;
        if (halt) begin
            nxt_st     = ST_IDLE;
            nxt_launch = 1'b0;
        end else if (go && q_nonzero) begin
            unique case (mid_st)
                ST_IDLE: begin
                    nxt_st     = ST_RUN;
                    nxt_launch = 1'b1;
                end
                ST_RUN:        nxt_st  = ST_RUN_QUEUED;
                ST_RUN_QUEUED: err_set = 1'b1;
                default:       nxt_st  = ST_IDLE;
            endcase
        end else if (drop && mid_st == ST_RUN_QUEUED) begin
            nxt_st = ST_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt_st;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_addr <= '0;
            a_len  <= '0;
            launch <= 1'b0;
            abort  <= 1'b0;
        end else if (halt) begin
            a_addr <= '0;
            a_len  <= '0;
            launch <= 1'b0;
            abort  <= (st != ST_IDLE);
        end else begin
            launch <= nxt_launch;
            abort  <= 1'b0;
            if (nxt_launch) begin
                a_addr <= q_addr;
                a_len  <= q_len;
            end
        end
    end

endmodule

// File: rtl/dmaq_seq.sv
module dmaq_seq
    import dmaq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              eng_start,
    output logic              eng_abort,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [LEN_W-1:0]  eng_words,
    input  logic              eng_done
);

    logic              wr_ok, cmd_hit;
    logic              cmd_go, cmd_drop, cmd_halt;
    logic              err_set, op_err;
    logic [ADDR_W-1:0] q_addr;
    logic [LEN_W-1:0]  q_len;
    logic [31:0]       scratch;
    seq_state_t        cur_st;

    assign wr_ok    = reg_wr && (reg_be == 4'hF);
    assign cmd_hit  = wr_ok && (reg_sel == IX_CMD);
    assign cmd_halt = cmd_hit && reg_wdata[CMD_HALT_BIT];
    assign cmd_drop = cmd_hit && !cmd_halt && reg_wdata[CMD_DROP_BIT];
    assign cmd_go   = cmd_hit && !cmd_halt && !cmd_drop && reg_wdata[CMD_GO_BIT];

    dmaq_cfg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cmd_halt),
        .wr_ok   (wr_ok),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .err_set (err_set),
        .q_addr  (q_addr),
        .q_len   (q_len),
        .scratch (scratch),
        .op_err  (op_err)
    );

    dmaq_ctl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) ctl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (cmd_go),
        .drop    (cmd_drop),
        .halt    (cmd_halt),
        .done    (eng_done),
        .q_addr  (q_addr),
        .q_len   (q_len),
        .st      (cur_st),
        .a_addr  (eng_addr),
        .a_len   (eng_words),
        .launch  (eng_start),
        .abort   (eng_abort),
        .err_set (err_set)
    );

    always_comb begin
        unique case (reg_sel)
            IX_STAT:    reg_rdata = 32'(cur_st);
            IX_ERR:     reg_rdata = 32'(op_err);
            IX_QADDR:   reg_rdata = 32'(q_addr);
            IX_QLEN:    reg_rdata = 32'(q_len);
            IX_AADDR:   reg_rdata = 32'(eng_addr);
            IX_ALEN:    reg_rdata = 32'(eng_words);
            IX_SCRATCH: reg_rdata = scratch;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmaq_seq_chk.sv
module dmaq_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        st,
    input logic              go,
    input logic              drop,
    input logic              halt,
    input logic              done,
    input logic [ADDR_W-1:0] q_addr,
    input logic [LEN_W-1:0]  q_len,
    input logic [ADDR_W-1:0] a_addr,
    input logic [LEN_W-1:0]  a_len,
    input logic              launch,
    input logic              op_err
);

    p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st != 2'b11);

    p_launch_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (a_len != '0));

    p_err_on_double_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'b10 && go && !done && q_len != '0) |=> op_err);

    p_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'b10 && done && !go && !drop && !halt && q_len != '0)
        |=> (launch && st == 2'b01 && a_addr == $past(q_addr)));

    p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'b10 && drop && !done) |=> (st == 2'b01 && !launch));

    p_halt_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (st == 2'b00 && a_addr == '0 && a_len == '0 && q_len == '0 && !op_err && !launch));

    p_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_addr[1:0] == 2'b00) && (q_addr[1:0] == 2'b00));

endmodule

bind dmaq_seq dmaq_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .st     (cur_st),
    .go     (cmd_go),
    .drop   (cmd_drop),
    .halt   (cmd_halt),
    .done   (eng_done),
    .q_addr (q_addr),
    .q_len  (q_len),
    .a_addr (eng_addr),
    .a_len  (eng_words),
    .launch (eng_start),
    .op_err (op_err)
);

// File: tb/dmaq_seq_tb_top.sv
`timescale 1ns/1ps
module dmaq_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_start, eng_abort, eng_done = 1'b0;
    logic [31:0] eng_addr;
    logic [15:0] eng_words;

    always #4 clk = ~clk;

    dmaq_seq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_start(eng_start), .eng_abort(eng_abort), .eng_addr(eng_addr),
        .eng_words(eng_words), .eng_done(eng_done)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int seen_launch = 0;
    int seen_abort = 0;
    always @(posedge clk) begin
        if (rst_n && eng_start) seen_launch <= seen_launch + 1;
        if (rst_n && eng_abort) seen_abort  <= seen_abort + 1;
    end

    int          m_st;
    logic [31:0] m_qa, m_aa, m_scr;
    logic [15:0] m_ql, m_al;
    bit          m_err;
    int          m_launch, m_abort;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit go_bits_halt(input logic [31:0] d); return d[2]; endfunction

    task automatic mdl(input bit w, input int sel, input logic [31:0] d, input logic [3:0] be, input bit dn);
        bit ok, h, c, g;
        ok = w && be == 4'hF;
        h  = ok && sel == 0 && go_bits_halt(d);
        c  = ok && sel == 0 && !h && d[1];
        g  = ok && sel == 0 && !h && !c && d[0];
        if (h) begin
            if (m_st != 0) m_abort++;
            m_st = 0; m_qa = 0; m_aa = 0; m_scr = 0; m_ql = 0; m_al = 0; m_err = 0;
            return;
        end
        if (dn) begin
            if (m_st == 1) m_st = 0;
            else if (m_st == 2) begin
                if (m_ql != 0) begin
                    m_aa = m_qa; m_al = m_ql; m_st = 1; m_launch++;
                end else m_st = 0;
            end
        end
        if (g && m_ql != 0) begin
            if (m_st == 0) begin
                m_aa = m_qa; m_al = m_ql; m_st = 1; m_launch++;
            end else if (m_st == 1) m_st = 2;
            else m_err = 1;
        end else if (c && m_st == 2) m_st = 1;
        if (ok) begin
            case (sel)
                2: if (d[0]) m_err = 0;
                3: m_qa = d & 32'hFFFF_FFFC;
                4: m_ql = d[15:0];
                7: m_scr = d;
                default: ;
            endcase
        end
    endtask

    task automatic step(input bit w, input int sel, input logic [31:0] d, input logic [3:0] be, input bit dn);
        @(negedge clk);
        reg_wr = w; reg_sel = 3'(sel); reg_wdata = d; reg_be = be; eng_done = dn;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; eng_done = 1'b0;
        mdl(w, sel, d, be, dn);
    endtask

    task automatic rd(input int sel, output logic [31:0] v);
        @(negedge clk);
        reg_sel = 3'(sel);
        #1 v = reg_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(1, v); chk(v == 32'(m_st), {tag, " R1 status"}, v, 32'(m_st));
        rd(2, v); chk(v == 32'(m_err), {tag, " R3 error bit"}, v, 32'(m_err));
        rd(3, v); chk(v == m_qa, {tag, " R8 queued addr"}, v, m_qa);
        rd(4, v); chk(v == 32'(m_ql), {tag, " R10 queued len"}, v, 32'(m_ql));
        rd(5, v); chk(v == m_aa, {tag, " R2 active addr"}, v, m_aa);
        rd(6, v); chk(v == 32'(m_al), {tag, " R2 active len"}, v, 32'(m_al));
        rd(7, v); chk(v == m_scr, {tag, " R9 scratch"}, v, m_scr);
        rd(0, v); chk(v == 0, {tag, " R10 cmd reads 0"}, v, 0);
        chk(eng_addr == m_aa && eng_words == m_al, {tag, " R2 engine outputs"}, eng_addr, m_aa);
        chk(seen_launch == m_launch, {tag, " R4 launch count"}, 32'(seen_launch), 32'(m_launch));
        chk(seen_abort == m_abort, {tag, " R6 abort count"}, 32'(seen_abort), 32'(m_abort));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        m_st = 0; m_qa = 0; m_aa = 0; m_scr = 0; m_ql = 0; m_al = 0; m_err = 0;
        m_launch = 0; m_abort = 0;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_all("reset R1");

        // R7: start with zero length does nothing
        step(1, 0, 32'h1, 4'hF, 0);
        check_all("zero-len R7");

        // R2 / R8: start from idle, unaligned address written
        step(1, 3, 32'h0000_1237, 4'hF, 0);
        step(1, 4, 32'h0000_8000, 4'hF, 0);
        step(1, 0, 32'h1, 4'hF, 0);
        chk(eng_start == 1'b1, "R2 launch pulse cycle", 32'(eng_start), 1);
        check_all("start R2");

        // R3: queue then double start
        step(1, 3, 32'h0000_2000, 4'hF, 0);
        step(1, 4, 32'h10, 4'hF, 0);
        step(1, 0, 32'h1, 4'hF, 0);
        check_all("queue R3");
        step(1, 0, 32'h1, 4'hF, 0);
        check_all("double start R3");
        step(1, 2, 32'h0, 4'hF, 0);
        check_all("err write0 R3");

        // R5: cancel in reserved, then cancel in run has no effect
        step(1, 0, 32'h2, 4'hF, 0);
        check_all("cancel R5");
        step(1, 0, 32'h2, 4'hF, 0);
        check_all("cancel in run R5");

        // R11: queue, then completion together with start
        step(1, 0, 32'h1, 4'hF, 0);
        step(1, 0, 32'h1, 4'hF, 1);
        check_all("done+go R11");
        // R11: start+cancel in one write -> cancel wins
        step(1, 0, 32'h3, 4'hF, 0);
        check_all("go+drop R11");

        // R4: chain with completion
        step(1, 3, 32'h0000_4444, 4'hF, 0);
        step(0, 0, 32'h0, 4'h0, 1);
        check_all("chain R4");
        step(0, 0, 32'h0, 4'h0, 1);
        check_all("finish R4");
        step(0, 0, 32'h0, 4'h0, 1);
        check_all("idle done R4");

        // R10: partial and read-only writes
        step(1, 7, 32'hDEAD_BEEF, 4'h7, 0);
        step(1, 5, 32'h1111_1110, 4'hF, 0);
        step(1, 1, 32'h2, 4'hF, 0);
        check_all("ignored writes R10");
        // R9: scratch
        step(1, 7, 32'hCAFE_F00D, 4'hF, 0);
        check_all("scratch R9");

        // R6: halt while running with all-bit command
        step(1, 0, 32'h1, 4'hF, 0);
        step(1, 0, 32'h7, 4'hF, 0);
        check_all("halt R6");

        // random mix
        for (int i = 0; i < 1500; i++) begin
            int r;
            logic [31:0] d;
            r = int'($urandom % 16);
            case (r)
                0, 1, 2, 3: step(1, 0, 32'h1, 4'hF, 0);
                4:  step(1, 0, 32'h2, 4'hF, 0);
                5:  if ($urandom % 6 == 0) step(1, 0, 32'h4, 4'hF, 0);
                    else step(1, 7, $urandom, 4'hF, 0);
                6, 7: step(0, 0, 32'h0, 4'h0, 1);
                8, 9: step(1, 3, $urandom, 4'hF, $urandom % 4 == 0);
                10: begin
                    d = ($urandom % 4 == 0) ? 32'h0 : ($urandom % 32'h8001) | ($urandom & 32'hFFFF_0000);
                    step(1, 4, d, 4'hF, 0);
                end
                11: step(1, 2, $urandom % 2, 4'hF, 0);
                12: step(1, 7, $urandom, 4'hF, 0);
                13: step(1, int'($urandom % 8), $urandom, 4'($urandom % 15), $urandom % 2);
                14: step(1, 1 + 4 * int'($urandom % 2) + int'($urandom % 2), $urandom, 4'hF, 0);
                default: step(1, 0, $urandom % 8, 4'hF, $urandom % 3 == 0);
            endcase
            if (i % 3 == 0) check_all("random R11");
        end
        check_all("final");
        finish_run();
    end

endmodule